// File: doc/BRIEF.md
# I2C Configuration Register Port

This block is a slave-only I2C target. It runs from a fast system clock and oversamples SCL and SDA. It holds two writable six-bit data registers (A and B), one pair of output-select bits shared by both, and a read-only snapshot of a five-bit input port. The surrounding logic uses the register contents and the select bits to steer a small output port. A one-cycle pulse marks every STOP seen on the bus, so downstream logic can apply new settings at transaction boundaries.

No register pointer is sent on the bus. In a write, each data byte steers itself: its two upper bits name the destination and its six lower bits carry the payload. A read always streams the same fixed order, starting from register A. The snapshot of the input port is taken on the first SCL rising edge after every START, so a read returns a coherent value. A pin chooses which of two fixed slave addresses the block answers to.

Top module: `i2c_cfg_port`

## Requirements
- R1: After a synchronous reset, both data registers read 0, the select bits hold 2'b10, SDA is released (`sda_drive_low` = 0) and `stop_pulse` is low.
- R2: The block acknowledges only the 7-bit address 1001110 when `addr_alt` = 0, and only 0110111 when `addr_alt` = 1. Any other address, including the general call 0000000, is not acknowledged, and the data bytes that follow it change nothing.
- R3: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Each STOP produces exactly one `stop_pulse` cycle and leaves SDA released.
- R4: A written data byte whose bits 7:6 are 00 loads bits 5:0 into register A and sets the select bits to 00. Register B does not change.
- R5: A written data byte whose bits 7:6 are 01 loads bits 5:0 into register B and sets the select bits to 01. Register A does not change.
- R6: A written byte with bits 7:6 = 10 sets only the select bits to 10. A byte with bits 7:6 = 11 changes nothing. The block acknowledges every data byte of an addressed write and applies each one in turn.
- R7: A read returns {00, A}, then {00, B}, then {000, snapshot}, MSB first. If the master keeps acknowledging, the sequence starts again at A.
- R8: The snapshot takes the input port value on the first SCL rising edge after each START or repeated START. Later changes on the port during the transaction are not seen.
- R9: Reads change neither data register nor the select bits.
- R10: When the master does not acknowledge a read byte, the block releases SDA and stays silent until STOP or a repeated START. A repeated START begins a new address match, so a master can end a read after any byte by not acknowledging it and then sending STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| addr_alt | input | 1 | Selects the slave address: 0 gives 1001110, 1 gives 0110111 |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| port_in | input | 5 | Input port sampled into the snapshot |
| sda_drive_low | output | 1 | Pulls SDA low when 1 (open-drain enable) |
| reg_a_q | output | 6 | Contents of data register A |
| reg_b_q | output | 6 | Contents of data register B |
| sel_q | output | 2 | Shared output-select bits |
| stop_pulse | output | 1 | One-cycle pulse for each STOP |

## Verification
The snapshot capture and the sampling of the first address bit fall on the same filtered SCL rising edge. The bench changes the input port half an SCL phase after that edge, both at an initial START and at a repeated START that follows a write. The third read byte must then hold the earlier value, while a later transaction must show the new one. In the same way, a write commit and the start of the block's ACK fall on one SCL falling edge. This is judged by sampling the ACK and by a per-clock comparison of A, B and the select bits against a behavioural model once the bus settles.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int PAY_W  = 6;
    localparam int PORT_W = 5;
    localparam int NUM_RD = 3;
    localparam int IDX_W  = $clog2(NUM_RD);
    localparam int BIT_W  = $clog2(BYTE_W + 1);

    localparam logic [6:0] ADDR_PRI   = 7'b1001110;
    localparam logic [6:0] ADDR_SEC   = 7'b0110111;
    localparam logic [6:0] ADDR_GCALL = 7'b0000000;
    localparam logic [1:0] SEL_RESET  = 2'b10;

    typedef enum logic [1:0] {
        DST_A   = 2'b00,
        DST_B   = 2'b01,
        DST_SEL = 2'b10,
        DST_RSV = 2'b11
    } dest_e;

    typedef struct packed {
        dest_e             dest;
        logic [PAY_W-1:0]  payload;
    } wr_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_WAIT
    } state_e;

    function automatic logic addr_hit(input logic [6:0] a, input logic alt);
        logic [6:0] own;
        own = alt ? ADDR_SEC : ADDR_PRI;
        return (a == own) && (a != ADDR_GCALL);
    endfunction

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(NUM_RD - 1)) ? '0 : i + 1'b1;
    endfunction

endpackage

// File: rtl/i2c_cfg_deglitch.sv
module i2c_cfg_deglitch #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   s_last;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    assign s_last = sync_q[SYNC_STAGES-1];

    // A new level is accepted only after FILT_LEN consecutive samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= 1'b1;
            cnt_q <= '0;
        end else if (s_last == dout) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
            dout  <= s_last;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_cfg_buscond.sv
module i2c_cfg_buscond (
    input  logic clk,
    input  logic rst,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_d;
    assign scl_fall  = ~scl_f & scl_d;
    assign bus_start = scl_f & scl_d & sda_d & ~sda_f;
    assign bus_stop  = scl_f & scl_d & ~sda_d & sda_f;
endmodule

// File: rtl/i2c_cfg_fsm.sv
module i2c_cfg_fsm
    import i2c_cfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  addr_alt,
    input  logic                  sda_f,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  bus_start,
    input  logic                  bus_stop,
    input  logic [BYTE_W-1:0]     rd_byte,
    output logic [IDX_W-1:0]      rd_idx,
    output logic                  sda_low,
    output logic                  stop_pulse,
    output logic                  wr_en,
    output wr_cmd_t               wr_cmd,
    output logic                  snap_en
);
    state_e               st;
    logic [BIT_W-1:0]     bit_cnt;
    logic [BYTE_W-1:0]    shreg;
    logic                 rw_rd;
    logic                 snap_arm;
    logic                 mst_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            rw_rd      <= 1'b0;
            snap_arm   <= 1'b0;
            mst_ack    <= 1'b0;
            rd_idx     <= '0;
            sda_low    <= 1'b0;
            stop_pulse <= 1'b0;
            wr_en      <= 1'b0;
            wr_cmd     <= '0;
            snap_en    <= 1'b0;
        end else begin
            stop_pulse <= 1'b0;
            wr_en      <= 1'b0;
            snap_en    <= 1'b0;
            if (bus_stop) begin
                st         <= ST_IDLE;
                sda_low    <= 1'b0;
                stop_pulse <= 1'b1;
                snap_arm   <= 1'b0;
            end else if (bus_start) begin
                st       <= ST_ADDR;
                bit_cnt  <= '0;
                sda_low  <= 1'b0;
                snap_arm <= 1'b1;
                rd_idx   <= '0;
            end else begin
                if (scl_rise && snap_arm) begin
                    snap_en  <= 1'b1;
                    snap_arm <= 1'b0;
                end
                unique case (st)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == BIT_W'(BYTE_W)) begin
                            if (addr_hit(shreg[7:1], addr_alt)) begin
                                sda_low <= 1'b1;
                                rw_rd   <= shreg[0];
                                st      <= ST_ADDR_ACK;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_rd) begin
                                shreg   <= rd_byte;
                                sda_low <= ~rd_byte[BYTE_W-1];
                                st      <= ST_RD;
                            end else begin
                                sda_low <= 1'b0;
                                st      <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == BIT_W'(BYTE_W)) begin
                            wr_en   <= 1'b1;
                            wr_cmd  <= wr_cmd_t'(shreg);
                            sda_low <= 1'b1;
                            st      <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_low <= 1'b0;
                            bit_cnt <= '0;
                            st      <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
                                sda_low <= 1'b0;
                                bit_cnt <= '0;
                                st      <= ST_RD_ACK;
                            end else begin
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_low <= ~shreg[BYTE_W-2];
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mst_ack <= ~sda_f;
                            if (!sda_f) rd_idx <= next_idx(rd_idx);
                        end else if (scl_fall) begin
                            if (mst_ack) begin
                                shreg   <= rd_byte;
                                sda_low <= ~rd_byte[BYTE_W-1];
                                st      <= ST_RD;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
    import i2c_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  wr_cmd_t             wr_cmd,
    input  logic                snap_en,
    input  logic [PORT_W-1:0]   port_in,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [BYTE_W-1:0]   rd_byte,
    output logic [PAY_W-1:0]    reg_a,
    output logic [PAY_W-1:0]    reg_b,
    output logic [1:0]          sel
);
    logic [PORT_W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_a  <= '0;
            reg_b  <= '0;
            sel    <= SEL_RESET;
            snap_q <= '0;
        end else begin
            if (snap_en) snap_q <= port_in;
            if (wr_en) begin
                unique case (wr_cmd.dest)
                    DST_A: begin
                        reg_a <= wr_cmd.payload;
                        sel   <= DST_A;
                    end
                    DST_B: begin
                        reg_b <= wr_cmd.payload;
                        sel   <= DST_B;
                    end
                    DST_SEL: sel <= DST_SEL;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (rd_idx)
            IDX_W'(0): rd_byte = {{(BYTE_W-PAY_W){1'b0}}, reg_a};
            IDX_W'(1): rd_byte = {{(BYTE_W-PAY_W){1'b0}}, reg_b};
            default:   rd_byte = {{(BYTE_W-PORT_W){1'b0}}, snap_q};
        endcase
    end
endmodule

// File: rtl/i2c_cfg_port.sv
module i2c_cfg_port
    import i2c_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_alt,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [PORT_W-1:0] port_in,
    output logic              sda_drive_low,
    output logic [PAY_W-1:0]  reg_a_q,
    output logic [PAY_W-1:0]  reg_b_q,
    output logic [1:0]        sel_q,
    output logic              stop_pulse
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, filt_lines;
    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic [IDX_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_byte;
    logic              wr_en, snap_en;
    wr_cmd_t           wr_cmd;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_cfg_deglitch #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_dg (
            .clk (clk),
            .rst (rst),
            .din (raw_lines[g]),
            .dout(filt_lines[g])
        );
    end

    i2c_cfg_buscond u_cond (
        .clk      (clk),
        .rst      (rst),
        .scl_f    (filt_lines[0]),
        .sda_f    (filt_lines[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    i2c_cfg_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .addr_alt  (addr_alt),
        .sda_f     (filt_lines[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .rd_byte   (rd_byte),
        .rd_idx    (rd_idx),
        .sda_low   (sda_drive_low),
        .stop_pulse(stop_pulse),
        .wr_en     (wr_en),
        .wr_cmd    (wr_cmd),
        .snap_en   (snap_en)
    );

    i2c_cfg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_cmd (wr_cmd),
        .snap_en(snap_en),
        .port_in(port_in),
        .rd_idx (rd_idx),
        .rd_byte(rd_byte),
        .reg_a  (reg_a_q),
        .reg_b  (reg_b_q),
        .sel    (sel_q)
    );
endmodule

// File: rtl/i2c_cfg_port_chk.sv
module i2c_cfg_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_in,
    input logic       sda_drive_low,
    input logic [5:0] reg_a_q,
    input logic [5:0] reg_b_q,
    input logic [1:0] sel_q,
    input logic       stop_pulse
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_q == 2'b10 && reg_a_q == '0 && reg_b_q == '0 && !sda_drive_low));

    assert_stop_single_R3: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> !stop_pulse);

    assert_stop_release_R3: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |-> !sda_drive_low);

    assert_a_write_sel_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_a_q != $past(reg_a_q)) |-> (sel_q == 2'b00));

    assert_b_write_sel_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_b_q != $past(reg_b_q)) |-> (sel_q == 2'b01));

    assert_sel_legal_R6: assert property (@(posedge clk) disable iff (rst)
        sel_q != 2'b11);

    assert_drive_in_low_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> !scl_in);
endmodule

bind i2c_cfg_port i2c_cfg_port_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .scl_in       (scl_in),
    .sda_drive_low(sda_drive_low),
    .reg_a_q      (reg_a_q),
    .reg_b_q      (reg_b_q),
    .sel_q        (sel_q),
    .stop_pulse   (stop_pulse)
);

// File: tb/i2c_cfg_port_tb_top.sv
module i2c_cfg_port_tb_top;
    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_alt = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [4:0] port_in = 5'h00;
    logic       sda_drive_low;
    logic [5:0] reg_a_q, reg_b_q;
    logic [1:0] sel_q;
    logic       stop_pulse;
    logic       sda_line;

    int n_chk = 0;
    int n_err = 0;
    bit settled = 1'b0;
    int stops_seen = 0;
    int exp_stops = 0;

    // behavioural model
    int m_a = 0, m_b = 0, m_sel = 2, m_snap = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_drive_low;

    i2c_cfg_port dut_i (
        .clk          (clk),
        .rst          (rst),
        .addr_alt     (addr_alt),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .port_in      (port_in),
        .sda_drive_low(sda_drive_low),
        .reg_a_q      (reg_a_q),
        .reg_b_q      (reg_b_q),
        .sel_q        (sel_q),
        .stop_pulse   (stop_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && stop_pulse) stops_seen++;
        if (!rst && settled) begin
            chk(int'(reg_a_q) == m_a, "R4 register A", int'(reg_a_q), m_a);
            chk(int'(reg_b_q) == m_b, "R5 register B", int'(reg_b_q), m_b);
            chk(int'(sel_q) == m_sel, "R6 select bits", int'(sel_q), m_sel);
            chk(sda_drive_low == 1'b0, "R3 SDA released when idle", int'(sda_drive_low), 0);
            chk(stops_seen == exp_stops, "R3 stop pulse count", stops_seen, exp_stops);
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_write(input logic [7:0] b);
        case (b[7:6])
            2'b00: begin m_a = int'(b[5:0]); m_sel = 0; end
            2'b01: begin m_b = int'(b[5:0]); m_sel = 1; end
            2'b10: m_sel = 2;
            default: ;
        endcase
    endtask

    task automatic bus_start();
        settled = 1'b0;
        m_snap = int'(port_in);
        sda_m = 1'b1; scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_rstart();
        m_snap = int'(port_in);
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
        exp_stops++;
        wt(H);
        settled = 1'b1;
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wt(H);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic bit_in(output logic v);
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H/2);
        v = sda_line; wt(H/2);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic v;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(v);
        acked = ~v;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            bit_in(v);
            b[i] = v;
        end
        bit_out(~give_ack);
    endtask

    function automatic int exp_rd(input int idx);
        case (idx % 3)
            0: return m_a;
            1: return m_b;
            default: return m_snap;
        endcase
    endfunction

    task automatic do_write(input logic [6:0] a, input logic [7:0] d[$], input bit hit, input string req);
        bit ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        chk(ack == hit, req, int'(ack), int'(hit));
        foreach (d[i]) begin
            send_byte(d[i], ack);
            chk(ack == hit, "R6 data byte acknowledge", int'(ack), int'(hit));
            if (hit) model_write(d[i]);
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input int n, input logic [4:0] new_port);
        bit ack;
        logic [7:0] b;
        fork
            begin
                @(posedge scl_m);
                wt(H/2);
                port_in = new_port;
            end
        join_none
        bus_start();
        send_byte({a, 1'b1}, ack);
        chk(ack == 1'b1, "R2 read address acknowledge", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk(int'(b) == exp_rd(i), "R7 R8 read byte", int'(b), exp_rd(i));
        end
        bus_stop();
    endtask

    initial begin
        logic [7:0] q[$];
        logic [7:0] b;
        logic v;
        bit ack;
        bit quiet;
        wt(5);
        chk(sda_drive_low == 1'b0, "R1 SDA released in reset", int'(sda_drive_low), 0);
        chk(stop_pulse == 1'b0, "R1 no stop pulse in reset", int'(stop_pulse), 0);
        chk(int'(sel_q) == 2, "R1 select reset value", int'(sel_q), 2);
        rst = 1'b0;
        wt(3);
        settled = 1'b1;
        wt(10);

        // R4, R5, R6: self-steered writes
        q = '{8'h2A};             do_write(7'h4E, q, 1'b1, "R2 R4 address acknowledge");
        q = '{8'h55};             do_write(7'h4E, q, 1'b1, "R2 R5 address acknowledge");
        q = '{8'hBF, 8'hC7};      do_write(7'h4E, q, 1'b1, "R6 address acknowledge");
        q = '{8'h01, 8'h43, 8'hFF}; do_write(7'h4E, q, 1'b1, "R6 multi-byte write");

        // R7, R8, R9: full read with wrap; port changes after the capture edge
        port_in = 5'h13;
        do_read(7'h4E, 4, 5'h0C);
        // next read must see the new port value (R8)
        do_read(7'h4E, 3, 5'h0C);
        // R10: end after the first byte
        do_read(7'h4E, 1, 5'h0C);

        // R2: foreign address and general call are ignored
        q = '{8'h15};             do_write(7'h37, q, 1'b0, "R2 foreign address ignored");
        q = '{8'h00};             do_write(7'h00, q, 1'b0, "R2 general call ignored");

        // R2: alternate address
        addr_alt = 1'b1;
        wt(5);
        q = '{8'h09};             do_write(7'h37, q, 1'b1, "R2 alternate address acknowledge");
        q = '{8'h7E};             do_write(7'h4E, q, 1'b0, "R2 primary address ignored when alternate");
        addr_alt = 1'b0;
        wt(5);

        // R10: NACK mid-read, silence, then repeated START into a write
        bus_start();
        send_byte({7'h4E, 1'b1}, ack);
        chk(ack == 1'b1, "R10 read address acknowledge", int'(ack), 1);
        recv_byte(1'b0, b);
        chk(int'(b) == m_a, "R10 first byte before NACK", int'(b), m_a);
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) begin
            bit_in(v);
            if (v !== 1'b1) quiet = 1'b0;
        end
        chk(quiet, "R10 silent after NACK", int'(quiet), 1);
        bus_rstart();
        send_byte({7'h4E, 1'b0}, ack);
        chk(ack == 1'b1, "R10 repeated START address", int'(ack), 1);
        send_byte(8'h92, ack);
        chk(ack == 1'b1, "R6 select-only byte acknowledge", int'(ack), 1);
        model_write(8'h92);
        bus_stop();

        // R8: write, repeated START, read; port change right after capture
        port_in = 5'h1B;
        bus_start();
        send_byte({7'h4E, 1'b0}, ack);
        chk(ack == 1'b1, "R4 write address acknowledge", int'(ack), 1);
        send_byte(8'h3C, ack);
        chk(ack == 1'b1, "R4 data acknowledge", int'(ack), 1);
        model_write(8'h3C);
        port_in = 5'h05;
        fork
            begin
                @(posedge scl_m);
                @(posedge scl_m);
                wt(H/2);
                port_in = 5'h1F;
            end
        join_none
        bus_rstart();
        send_byte({7'h4E, 1'b1}, ack);
        chk(ack == 1'b1, "R8 read after repeated START", int'(ack), 1);
        for (int i = 0; i < 3; i++) begin
            recv_byte(i < 2, b);
            chk(int'(b) == exp_rd(i), "R8 snapshot at repeated START", int'(b), exp_rd(i));
        end
        bus_stop();

        wt(20);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule